// File: doc/BRIEF.md
# Fetch Thread Selector

This block sits in front of the fetch stage of a multi-threaded core and decides, every cycle, which hardware thread the fetch stage serves next. For each thread it takes an activity bit, a three-bit fetch state code and two occupancy counts: instruction queue and load/store queue. It returns a single grant: a valid flag and the thread number.

A two-bit policy input selects the rule. Single-thread mode always names thread 0. Rotating mode keeps an ordered list of thread numbers and takes the first usable one from the front; an accepted grant sends that thread to the back of the list. The two occupancy modes pick the usable thread with the smallest count. The pick is combinational from inputs that are already registered upstream. The list moves only on a clock edge where the consumer raises the accept strobe.

Top module: `fetch_thread_pick`

## Requirements
- R1: A thread is usable only when its active bit is set and its state code is 0 (running), 1 (idle) or 5 (cache fill done). Codes 2 (squashing), 3 (blocked), 4 (waiting on fill), 6 (waiting on retry) and 7 never make a thread usable. The state of thread i is held in status_i bits 3i+2 to 3i.
- R2: With policy 1 (rotating), the grant goes to the first usable thread found when the priority list is scanned from its head.
- R3: In rotating mode, a clock edge with pick_valid_o and grant_ack_i high moves the granted thread to the tail of the list. The other threads keep their relative order.
- R4: When no thread is usable, pick_valid_o is low and pick_tid_o reads 0. This applies under policies 1, 2 and 3, and under every policy when only one thread is configured.
- R5: With policy 0 (single-thread) and more than one thread configured, pick_valid_o is high and pick_tid_o is 0, whatever the states are.
- R6: With one thread configured, thread 0 is granted exactly when it is usable, under every policy.
- R7: After reset the priority list holds the thread numbers in ascending order, with thread 0 at the head.
- R8: With policy 2, the usable thread with the smallest instruction-queue count wins. Ties go to the lower thread number. The count of thread i is iq_cnt_i bits CW·i+CW−1 to CW·i.
- R9: With policy 3, the same rule applies to the load/store-queue counts in lsq_cnt_i, which use the same field layout.
- R10: The list changes only on an accepted grant in rotating mode. grant_ack_i has no effect while no grant is valid or while policy 0, 2 or 3 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Selection rule: 0 single, 1 rotating, 2 fewest IQ, 3 fewest LSQ |
| active_i | input | N | Per-thread active bit |
| status_i | input | 3·N | Per-thread fetch state code |
| iq_cnt_i | input | CW·N | Per-thread instruction-queue occupancy |
| lsq_cnt_i | input | CW·N | Per-thread load/store-queue occupancy |
| grant_ack_i | input | 1 | Consumer accepts the current grant this cycle |
| pick_valid_o | output | 1 | A thread is granted |
| pick_tid_o | output | max(1,clog2(N)) | Granted thread number |

## Verification
The hardest condition to reach is a priority list that no longer matches thread-number order, while some threads are unusable, so that the scan skips entries and lands deep in the list. The stimulus table chains accepted grants under changing masks and states to push the list through several permutations. It then probes that list with patterns that block the head threads. The same table slips in accepts while nothing is granted and while an occupancy policy is selected, then returns to rotating mode to show the order has not moved.

// File: rtl/fetch_pick_pkg.sv
package fetch_pick_pkg;
   localparam int SW = 3;

   typedef enum logic [SW-1:0] {
      ST_RUN        = 3'd0,
      ST_IDLE       = 3'd1,
      ST_SQUASH     = 3'd2,
      ST_BLOCK      = 3'd3,
      ST_FILL_WAIT  = 3'd4,
      ST_FILL_DONE  = 3'd5,
      ST_RETRY_WAIT = 3'd6,
      ST_SPARE      = 3'd7
   } thr_state_e;

   typedef enum logic [1:0] {
      POL_SOLO      = 2'd0,
      POL_ROTATE    = 2'd1,
      POL_IQ_LEAST  = 2'd2,
      POL_LSQ_LEAST = 2'd3
   } pick_policy_e;

   function automatic logic may_fetch(input logic [SW-1:0] s);
      return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FILL_DONE);
   endfunction
endpackage

// File: rtl/fetch_pick_elig.sv
module fetch_pick_elig
   import fetch_pick_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [N-1:0]    active_i,
   input  logic [N*SW-1:0] status_i,
   output logic [N-1:0]    ok_o
);
   for (genvar i = 0; i < N; i++) begin : g_thr
      assign ok_o[i] = active_i[i] & may_fetch(status_i[i*SW +: SW]);
   end
endmodule

// File: rtl/fetch_pick_rotate.sv
module fetch_pick_rotate #(
   parameter int N  = 4,
   parameter int TW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  ok_i,
   input  logic          adv_i,
   output logic          hit_o,
   output logic [TW-1:0] tid_o
);
   logic [TW-1:0] order_q [N];
   logic [TW-1:0] order_d [N];
   logic [TW-1:0] hit_pos;

   always_comb begin
      hit_o   = 1'b0;
      tid_o   = '0;
      hit_pos = '0;
      for (int k = 0; k < N; k++) begin
         if (!hit_o && ok_i[order_q[k]]) begin
            hit_o   = 1'b1;
            tid_o   = order_q[k];
            hit_pos = TW'(k);
         end
      end
   end

   always_comb begin
      for (int k = 0; k < N; k++) order_d[k] = order_q[k];
      if (adv_i && hit_o) begin
         for (int k = 0; k < N - 1; k++) begin
            if (k >= int'(hit_pos)) order_d[k] = order_q[k+1];
         end
         order_d[N-1] = tid_o;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) order_q[k] <= TW'(k);
      end else begin
         for (int k = 0; k < N; k++) order_q[k] <= order_d[k];
      end
   end
endmodule

// File: rtl/fetch_pick_least.sv
module fetch_pick_least #(
   parameter int N  = 4,
   parameter int CW = 4,
   parameter int TW = 2
) (
   input  logic [N-1:0]    ok_i,
   input  logic [N*CW-1:0] cnt_i,
   output logic            hit_o,
   output logic [TW-1:0]   tid_o
);
   logic [CW-1:0] best;

   always_comb begin
      hit_o = 1'b0;
      tid_o = '0;
      best  = '0;
      for (int k = 0; k < N; k++) begin
         if (ok_i[k] && (!hit_o || cnt_i[k*CW +: CW] < best)) begin
            hit_o = 1'b1;
            tid_o = TW'(k);
            best  = cnt_i[k*CW +: CW];
         end
      end
   end
endmodule

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick
   import fetch_pick_pkg::*;
#(
   parameter int N  = 4,
   parameter int CW = 4,
   localparam int TW = (N > 1) ? $clog2(N) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      policy_i,
   input  logic [N-1:0]    active_i,
   input  logic [N*SW-1:0] status_i,
   input  logic [N*CW-1:0] iq_cnt_i,
   input  logic [N*CW-1:0] lsq_cnt_i,
   input  logic            grant_ack_i,
   output logic            pick_valid_o,
   output logic [TW-1:0]   pick_tid_o
);
   if (N < 1 || N > 4) begin : g_bad_n
      $error("fetch_thread_pick: N must lie in 1..4");
   end
   if (CW < 1) begin : g_bad_cw
      $error("fetch_thread_pick: CW must be at least 1");
   end

   logic [N-1:0] ok;

   fetch_pick_elig #(.N(N)) i_elig (
      .active_i (active_i),
      .status_i (status_i),
      .ok_o     (ok)
   );

   if (N == 1) begin : g_one
      assign pick_valid_o = ok[0];
      assign pick_tid_o   = '0;
   end else begin : g_multi
      logic          rr_hit, iq_hit, lsq_hit;
      logic [TW-1:0] rr_tid, iq_tid, lsq_tid;
      logic          rr_adv;

      assign rr_adv = grant_ack_i && (policy_i == POL_ROTATE);

      fetch_pick_rotate #(.N(N), .TW(TW)) i_rot (
         .clk   (clk),
         .rst_n (rst_n),
         .ok_i  (ok),
         .adv_i (rr_adv),
         .hit_o (rr_hit),
         .tid_o (rr_tid)
      );

      fetch_pick_least #(.N(N), .CW(CW), .TW(TW)) i_iq (
         .ok_i  (ok),
         .cnt_i (iq_cnt_i),
         .hit_o (iq_hit),
         .tid_o (iq_tid)
      );

      fetch_pick_least #(.N(N), .CW(CW), .TW(TW)) i_lsq (
         .ok_i  (ok),
         .cnt_i (lsq_cnt_i),
         .hit_o (lsq_hit),
         .tid_o (lsq_tid)
      );

      always_comb begin
         unique case (policy_i)
            POL_SOLO:      begin pick_valid_o = 1'b1;    pick_tid_o = '0;      end
            POL_ROTATE:    begin pick_valid_o = rr_hit;  pick_tid_o = rr_tid;  end
            POL_IQ_LEAST:  begin pick_valid_o = iq_hit;  pick_tid_o = iq_tid;  end
            default:       begin pick_valid_o = lsq_hit; pick_tid_o = lsq_tid; end
         endcase
      end
   end
endmodule

// File: rtl/fetch_thread_pick_chk.sv
module fetch_thread_pick_chk #(
   parameter int N  = 4,
   parameter int CW = 4,
   parameter int TW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      policy_i,
   input logic [N-1:0]    active_i,
   input logic [N*3-1:0]  status_i,
   input logic [N*CW-1:0] iq_cnt_i,
   input logic [N*CW-1:0] lsq_cnt_i,
   input logic            grant_ack_i,
   input logic            pick_valid_o,
   input logic [TW-1:0]   pick_tid_o
);
   logic [N-1:0] usable;
   logic         any_usable, solo_multi, iq_better, lsq_better, tid_usable;

   always_comb begin
      for (int j = 0; j < N; j++) begin
         usable[j] = active_i[j] &&
            (status_i[j*3 +: 3] == 3'd0 || status_i[j*3 +: 3] == 3'd1 ||
             status_i[j*3 +: 3] == 3'd5);
      end
      any_usable = |usable;
      solo_multi = (N > 1) && (policy_i == 2'd0);
      tid_usable = 1'b0;
      iq_better  = 1'b0;
      lsq_better = 1'b0;
      for (int j = 0; j < N; j++) begin
         if (int'(pick_tid_o) == j) tid_usable = usable[j];
      end
      for (int j = 0; j < N; j++) begin
         for (int t = 0; t < N; t++) begin
            if (int'(pick_tid_o) == t && usable[j]) begin
               if (iq_cnt_i[j*CW +: CW] < iq_cnt_i[t*CW +: CW] ||
                   (iq_cnt_i[j*CW +: CW] == iq_cnt_i[t*CW +: CW] && j < t))
                  iq_better = 1'b1;
               if (lsq_cnt_i[j*CW +: CW] < lsq_cnt_i[t*CW +: CW] ||
                   (lsq_cnt_i[j*CW +: CW] == lsq_cnt_i[t*CW +: CW] && j < t))
                  lsq_better = 1'b1;
            end
         end
      end
   end

   // R1: a granted thread must be usable (outside single-thread mode)
   p_grant_usable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid_o && !solo_multi) |-> tid_usable);

   // R4: nothing usable means no grant
   p_none_usable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_usable && !solo_multi) |-> (!pick_valid_o && pick_tid_o == '0));

   // R5: single-thread mode pins thread 0
   p_solo_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      solo_multi |-> (pick_valid_o && pick_tid_o == '0));

   // R8: fewest instruction-queue entries wins
   p_iq_least_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (N > 1 && policy_i == 2'd2 && pick_valid_o) |-> !iq_better);

   // R9: fewest load/store-queue entries wins
   p_lsq_least_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (N > 1 && policy_i == 2'd3 && pick_valid_o) |-> !lsq_better);

   // R10: with no accept, unchanged inputs give an unchanged grant
   p_hold_no_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_i == 2'd1 && !grant_ack_i) ##1
      (policy_i == 2'd1 && $stable(active_i) && $stable(status_i))
      |-> ($stable(pick_valid_o) && $stable(pick_tid_o)));
endmodule

bind fetch_thread_pick fetch_thread_pick_chk #(.N(N), .CW(CW), .TW(TW)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .policy_i     (policy_i),
   .active_i     (active_i),
   .status_i     (status_i),
   .iq_cnt_i     (iq_cnt_i),
   .lsq_cnt_i    (lsq_cnt_i),
   .grant_ack_i  (grant_ack_i),
   .pick_valid_o (pick_valid_o),
   .pick_tid_o   (pick_tid_o)
);

// File: tb/test_fetch_thread_pick.sv
module test_fetch_thread_pick;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]  policy;
   logic [3:0]  active;
   logic [11:0] status;
   logic [15:0] iq, lsq;
   logic        ack;
   logic        pv;
   logic [1:0]  pt;

   logic [1:0]  p1_policy;
   logic        p1_active;
   logic [2:0]  p1_status;
   logic        p1_ack;
   logic        p1_v;
   logic        p1_t;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   fetch_thread_pick #(.N(4), .CW(4)) i_fetch_thread_pick (
      .clk(clk), .rst_n(rst_n), .policy_i(policy), .active_i(active),
      .status_i(status), .iq_cnt_i(iq), .lsq_cnt_i(lsq),
      .grant_ack_i(ack), .pick_valid_o(pv), .pick_tid_o(pt));

   fetch_thread_pick #(.N(1), .CW(4)) i_fetch_thread_pick_one (
      .clk(clk), .rst_n(rst_n), .policy_i(p1_policy), .active_i(p1_active),
      .status_i(p1_status), .iq_cnt_i(4'd0), .lsq_cnt_i(4'd0),
      .grant_ack_i(p1_ack), .pick_valid_o(p1_v), .pick_tid_o(p1_t));

   function automatic logic [11:0] st4(int s3, int s2, int s1, int s0);
      return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
   endfunction
   function automatic logic [15:0] cn4(int c3, int c2, int c1, int c0);
      return {4'(c3), 4'(c2), 4'(c1), 4'(c0)};
   endfunction

   typedef struct packed {
      logic [3:0]  rq;
      logic [1:0]  pol;
      logic [3:0]  act;
      logic [11:0] st;
      logic [15:0] iqc;
      logic [15:0] lsqc;
      logic        a;
      logic        ev;
      logic [1:0]  et;
   } vec_t;

   localparam vec_t VECS [17] = '{
      '{4'd2,  2'd1, 4'hF, st4(0,0,0,0), 16'h0, 16'h0, 1'b1, 1'b1, 2'd0}, // R2 list 0123 -> 1230
      '{4'd3,  2'd1, 4'hF, st4(0,0,0,0), 16'h0, 16'h0, 1'b1, 1'b1, 2'd1}, // R3 -> 2301
      '{4'd2,  2'd1, 4'hF, st4(2,3,0,0), 16'h0, 16'h0, 1'b1, 1'b1, 2'd0}, // R2 skip 2,3 -> 2310
      '{4'd10, 2'd1, 4'hF, st4(0,0,0,0), 16'h0, 16'h0, 1'b0, 1'b1, 2'd2}, // R10 no ack
      '{4'd3,  2'd1, 4'hF, st4(0,0,0,0), 16'h0, 16'h0, 1'b1, 1'b1, 2'd2}, // R3 -> 3102
      '{4'd1,  2'd1, 4'h6, st4(0,0,0,0), 16'h0, 16'h0, 1'b1, 1'b1, 2'd1}, // R1 inactive 3 -> 3021
      '{4'd1,  2'd1, 4'hF, st4(5,4,4,4), 16'h0, 16'h0, 1'b1, 1'b1, 2'd3}, // R1 fill done -> 0213
      '{4'd1,  2'd1, 4'hF, st4(0,0,0,1), 16'h0, 16'h0, 1'b0, 1'b1, 2'd0}, // R1 idle usable
      '{4'd4,  2'd1, 4'hF, st4(3,3,3,3), 16'h0, 16'h0, 1'b1, 1'b0, 2'd0}, // R4 none usable
      '{4'd10, 2'd1, 4'hF, st4(0,0,0,0), 16'h0, 16'h0, 1'b0, 1'b1, 2'd0}, // R10 ack with no grant ignored
      '{4'd3,  2'd1, 4'hF, st4(0,0,0,3), 16'h0, 16'h0, 1'b0, 1'b1, 2'd2}, // R3 order 0213 kept
      '{4'd8,  2'd2, 4'hF, st4(0,0,0,0), cn4(7,3,3,5), 16'h0, 1'b1, 1'b1, 2'd1}, // R8 tie low id
      '{4'd8,  2'd2, 4'hF, st4(0,0,3,0), cn4(7,3,3,5), 16'h0, 1'b1, 1'b1, 2'd2}, // R8 skip blocked
      '{4'd9,  2'd3, 4'hB, st4(0,0,0,0), 16'h0, cn4(0,0,9,2), 1'b1, 1'b1, 2'd3}, // R9 inactive 2
      '{4'd4,  2'd3, 4'hF, st4(4,4,4,4), 16'h0, cn4(1,1,1,1), 1'b1, 1'b0, 2'd0}, // R4 all waiting
      '{4'd10, 2'd1, 4'hF, st4(0,0,0,3), 16'h0, 16'h0, 1'b0, 1'b1, 2'd2}, // R10 other-mode acks ignored
      '{4'd5,  2'd0, 4'hF, st4(3,3,3,3), 16'h0, 16'h0, 1'b0, 1'b1, 2'd0}  // R5 solo
   };

   task automatic chk(string req, logic v, logic [1:0] t, logic ev, logic [1:0] et);
      checks++;
      if (v !== ev || t !== et) begin
         errors++;
         $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                  req, v, t, ev, et);
      end
   endtask

   task automatic drive(logic [1:0] p, logic [3:0] a, logic [11:0] s,
                        logic [15:0] q, logic [15:0] l, logic k);
      @(negedge clk);
      policy = p; active = a; status = s; iq = q; lsq = l; ack = k;
      #1;
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      policy = 2'd1; active = 4'h0; status = '0; iq = '0; lsq = '0; ack = 1'b0;
      p1_policy = 2'd1; p1_active = 1'b0; p1_status = 3'd0; p1_ack = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R7: ascending order after reset
      drive(2'd1, 4'hF, st4(0,0,0,0), 16'h0, 16'h0, 1'b0);
      chk("R7 head", pv, pt, 1'b1, 2'd0);
      drive(2'd1, 4'hF, st4(0,0,0,3), 16'h0, 16'h0, 1'b0);
      chk("R7 second", pv, pt, 1'b1, 2'd1);
      drive(2'd1, 4'hF, st4(0,0,2,3), 16'h0, 16'h0, 1'b0);
      chk("R7 third", pv, pt, 1'b1, 2'd2);

      for (int i = 0; i < 17; i++) begin
         drive(VECS[i].pol, VECS[i].act, VECS[i].st, VECS[i].iqc, VECS[i].lsqc, VECS[i].a);
         chk($sformatf("R%0d vec%0d", VECS[i].rq, i), pv, pt, VECS[i].ev, VECS[i].et);
      end

      // R8: only the largest-count thread lower by one wins
      drive(2'd2, 4'hF, st4(0,0,0,0), cn4(14,15,15,15), 16'h0, 1'b0);
      chk("R8 max counts", pv, pt, 1'b1, 2'd3);
      // R1: retry-wait and spare codes never usable
      drive(2'd1, 4'hF, st4(7,6,7,6), 16'h0, 16'h0, 1'b0);
      chk("R1 codes 6/7", pv, pt, 1'b0, 2'd0);

      // R6: single configured thread
      ack = 1'b0;
      @(negedge clk);
      p1_policy = 2'd1; p1_active = 1'b1; p1_status = 3'd0; #1;
      chk("R6 one usable", p1_v, {1'b0, p1_t}, 1'b1, 2'd0);
      @(negedge clk);
      p1_status = 3'd3; #1;
      chk("R6 one blocked", p1_v, {1'b0, p1_t}, 1'b0, 2'd0);
      @(negedge clk);
      p1_policy = 2'd0; #1;
      chk("R6 solo blocked", p1_v, {1'b0, p1_t}, 1'b0, 2'd0);
      @(negedge clk);
      p1_policy = 2'd2; p1_status = 3'd5; p1_active = 1'b0; #1;
      chk("R6 inactive", p1_v, {1'b0, p1_t}, 1'b0, 2'd0);
      @(negedge clk);
      p1_active = 1'b1; p1_ack = 1'b1; #1;
      chk("R6 fill done", p1_v, {1'b0, p1_t}, 1'b1, 2'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule